// File: doc/BRIEF.md
# Full-Page Column Write Burst Engine

This block drives the column side of a synchronous memory model while a write burst runs in full-page mode. A WRITE command gives a start column and a bank. From that cycle on, the engine issues one column beat per clock into a row buffer of 256 words for each bank. The column counter runs modulo the row length, so the burst has no natural end. After the last column of the row it continues from the start column again, and it keeps going until a burst-stop command or a precharge to the same bank ends it. The stop takes effect in the cycle it is issued, whatever read latency the surrounding device is set to. No latency setting reaches this block.

Write data arrives on a valid/ready stream. The burst never waits for data. `wr_ready` is high in every cycle that is a beat slot. A slot in which `wr_valid` is low is masked: that column is not written, but the column still advances. The upstream side can only fill slots and cannot apply back-pressure to the burst. After a stop, a flag shows that a precharge is now permitted. A programmable cycle limit then watches for that precharge and raises an error if it does not arrive in time.

Top module: `fpb_write_engine`

## Requirements
- R1: In the cycle of a WRITE (`cmd_op` = 1), `wr_ready` is high, and `buf_col`/`buf_bank` equal `cmd_col`/`cmd_bank`. The word on `wr_data` is written there if `wr_valid` is high.
- R2: In each later cycle of a running burst, `buf_col` is the previous beat's column plus one, modulo 256. After 256 beats the column is the start column again, and it keeps counting for as long as the burst runs.
- R3: A running burst ends only on a burst stop or a precharge to its own bank. From the next cycle on, `wr_ready` stays low until the next WRITE.
- R4: In the cycle of a burst stop (`cmd_op` = 2), nothing is written and `wr_ready` is low, even with `wr_valid` high. The stop latency is zero cycles.
- R5: `buf_we` is high exactly when `wr_valid` and `wr_ready` are both high. A beat slot with `wr_valid` low leaves its column unwritten but still advances the column.
- R6: After a stop that ends a burst, `pre_ok` is high from the next cycle. It stays high until a precharge to the stopped bank or a new WRITE.
- R7: Count the stop cycle as cycle t and let L be `tras_limit` (L >= 1). If no precharge to the stopped bank occurs in cycles t+1 to t+L, `tras_err` is high from cycle t+L+1. It stays high until a precharge to that bank.
- R8: A WRITE issued during a running burst restarts the burst at the new column and bank in the same cycle.
- R9: A precharge (`cmd_op` = 3) to the burst's bank ends the burst with no write in that cycle. A precharge to another bank leaves the burst running.
- R10: `rd_data` shows the stored word at `rd_bank`/`rd_col` combinationally. Columns that were never strobed keep their previous contents.
- R11: While reset is held and right after it, `wr_ready`, `buf_we`, `pre_ok` and `tras_err` are low and the row buffers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | 0 none, 1 write, 2 burst stop, 3 precharge |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_col | input | COL_W | Start column of a write |
| tras_limit | input | TRAS_W | Cycles allowed between stop and precharge |
| wr_valid | input | 1 | Write data present |
| wr_data | input | DATA_W | Write data word |
| wr_ready | output | 1 | Current cycle is a beat slot |
| buf_we | output | 1 | Row buffer write strobe |
| buf_bank | output | BANK_W | Bank of the current beat |
| buf_col | output | COL_W | Column of the current beat |
| rd_bank | input | BANK_W | Read-back bank |
| rd_col | input | COL_W | Read-back column |
| rd_data | output | DATA_W | Stored word at the read-back address |
| pre_ok | output | 1 | Stop seen, precharge permitted |
| tras_err | output | 1 | Precharge window after stop expired |

## Verification
The main burst path is tried with the following patterns:
- A burst that starts near the top of the row and runs past 256 beats. This separates a true modulo-256 wrap back to the start column from a burst that saturates or ends at the row boundary.
- Data streams with gaps. These separate slots that are masked from slots that stall the column.
- Stops and precharges issued with `wr_valid` high. These show whether termination has zero latency.
- A restart in the middle of a burst, and precharges to the other bank. These show which commands really end a burst.
- A long random command mix, compared against a behavioural model on every clock. This covers the timeout limit at both edges of its window.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2,
    OP_PRE   = 2'd3
  } fpb_op_e;
endpackage

// File: rtl/fpb_col_ctr.sv
module fpb_col_ctr
  import fpb_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpb_op_e           op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              beat,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic              stop_evt
);
  logic              on_q;
  logic [COL_W-1:0]  col_q;
  logic [BANK_W-1:0] bank_q;
  logic              start, kill_stop, kill_pre;

  always_comb begin
    start     = (op == OP_WRITE);
    kill_stop = on_q && (op == OP_STOP);
    kill_pre  = on_q && (op == OP_PRE) && (cmd_bank == bank_q);
    beat      = start || (on_q && !kill_stop && !kill_pre);
    beat_col  = start ? cmd_col  : col_q;
    beat_bank = start ? cmd_bank : bank_q;
    stop_evt  = kill_stop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      col_q  <= '0;
      bank_q <= '0;
    end else if (start) begin
      on_q   <= 1'b1;
      col_q  <= cmd_col + 1'b1;
      bank_q <= cmd_bank;
    end else if (kill_stop || kill_pre) begin
      on_q   <= 1'b0;
    end else if (on_q) begin
      col_q  <= col_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpb_tras_timer.sv
module fpb_tras_timer
  import fpb_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int TRAS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpb_op_e           op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              stop_evt,
  input  logic [BANK_W-1:0] stop_bank,
  input  logic [TRAS_W-1:0] limit,
  output logic              pre_ok,
  output logic              err
);
  logic              waiting;
  logic [TRAS_W-1:0] cnt;
  logic [BANK_W-1:0] wbank;
  logic              pre_hit;

  assign pre_hit = (op == OP_PRE) && (cmd_bank == wbank);
  assign pre_ok  = waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      cnt     <= '0;
      wbank   <= '0;
    end else if (stop_evt) begin
      waiting <= 1'b1;
      cnt     <= TRAS_W'(1);
      wbank   <= stop_bank;
    end else if (waiting && pre_hit) begin
      waiting <= 1'b0;
    end else if (op == OP_WRITE) begin
      waiting <= 1'b0;
    end else if (waiting && cnt < limit) begin
      cnt     <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (pre_hit) begin
      err <= 1'b0;
    end else if (waiting && op != OP_WRITE && cnt >= limit) begin
      err <= 1'b1;
    end
  end
endmodule

// File: rtl/fpb_row_buf.sv
module fpb_row_buf #(
  parameter int NUM_BANKS = 2,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int DEPTH    = 1 << COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wbank,
  input  logic [COL_W-1:0]  wcol,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BANK_W-1:0] rbank,
  input  logic [COL_W-1:0]  rcol,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && wbank == BANK_W'(g)) begin
        mem[wcol] <= wdata;
      end
    end
    assign bank_rd[g] = mem[rcol];
  end

  assign rdata = bank_rd[rbank];
endmodule

// File: rtl/fpb_write_engine.sv
module fpb_write_engine
  import fpb_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int TRAS_W    = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [TRAS_W-1:0] tras_limit,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              buf_we,
  output logic [BANK_W-1:0] buf_bank,
  output logic [COL_W-1:0]  buf_col,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              pre_ok,
  output logic              tras_err
);
  fpb_op_e op;
  logic    stop_evt;

  assign op     = fpb_op_e'(cmd_op);
  assign buf_we = wr_ready && wr_valid;

  fpb_col_ctr #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .op(op), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .beat(wr_ready), .beat_col(buf_col), .beat_bank(buf_bank), .stop_evt(stop_evt)
  );

  fpb_tras_timer #(.BANK_W(BANK_W), .TRAS_W(TRAS_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .op(op), .cmd_bank(cmd_bank),
    .stop_evt(stop_evt), .stop_bank(buf_bank), .limit(tras_limit),
    .pre_ok(pre_ok), .err(tras_err)
  );

  fpb_row_buf #(.NUM_BANKS(NUM_BANKS), .COL_W(COL_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .wbank(buf_bank), .wcol(buf_col),
    .wdata(wr_data), .rbank(rd_bank), .rcol(rd_col), .rdata(rd_data)
  );
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int BANK_W = 1,
  parameter int COL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_op,
  input logic              wr_ready,
  input logic              buf_we,
  input logic [BANK_W-1:0] buf_bank,
  input logic [COL_W-1:0]  buf_col,
  input logic              pre_ok,
  input logic              tras_err
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R4: a stop cycle is never a beat slot and never writes
  p_stop_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 2'd2) |-> (!buf_we && !wr_ready));

  // R2: consecutive beat slots step the column by one in the same bank
  p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(wr_ready) && wr_ready && cmd_op != 2'd1)
      |-> (buf_col == COL_W'($past(buf_col) + 1'b1) && buf_bank == $past(buf_bank)));

  // R3: after a stop no slot opens until a new write
  p_idle_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(cmd_op) == 2'd2 && cmd_op != 2'd1) |-> !wr_ready);

  // R6: a stop that ends a live burst opens the precharge window
  p_pre_ok_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(wr_ready, 2) && $past(cmd_op) == 2'd2) |-> pre_ok);

  // R7: the timeout only rises inside an open precharge window
  p_err_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tras_err) |-> pre_ok);
endmodule

bind fpb_write_engine fpb_checker #(.BANK_W(BANK_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .wr_ready(wr_ready), .buf_we(buf_we),
  .buf_bank(buf_bank), .buf_col(buf_col), .pre_ok(pre_ok), .tras_err(tras_err)
);

// File: tb/sim_fpb_write_engine.sv
module sim_fpb_write_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cmd_op;
  logic [0:0]  cmd_bank;
  logic [7:0]  cmd_col;
  logic [15:0] tras_limit;
  logic        wr_valid;
  logic [15:0] wr_data;
  logic        wr_ready, buf_we;
  logic [0:0]  buf_bank;
  logic [7:0]  buf_col;
  logic [0:0]  rd_bank;
  logic [7:0]  rd_col;
  logic [15:0] rd_data;
  logic        pre_ok, tras_err;

  always #5 clk = ~clk;

  fpb_write_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .tras_limit(tras_limit), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .buf_we(buf_we), .buf_bank(buf_bank), .buf_col(buf_col), .rd_bank(rd_bank),
    .rd_col(rd_col), .rd_data(rd_data), .pre_ok(pre_ok), .tras_err(tras_err)
  );

  int n_chk = 0, n_bad = 0;
  // reference model state
  bit          m_on, m_wait, m_err;
  int          m_col, m_bank, m_cnt, m_wbank, lim;
  logic [15:0] mem [2][256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int op, input int bank, input int col, input bit v, input int d);
    bit e_rdy;
    int e_col, e_bank, rb, rc;
    bit stop_evt, pre_hit;
    cmd_op = op[1:0]; cmd_bank = bank[0:0]; cmd_col = col[7:0];
    wr_valid = v; wr_data = d[15:0]; tras_limit = lim[15:0];
    rb = $urandom_range(0, 1); rc = $urandom_range(0, 255);
    rd_bank = rb[0:0]; rd_col = rc[7:0];
    e_rdy = 0; e_col = 0; e_bank = 0;
    if (op == 1) begin e_rdy = 1; e_col = col; e_bank = bank; end
    else if (m_on && op != 2 && !(op == 3 && bank == m_bank)) begin
      e_rdy = 1; e_col = m_col; e_bank = m_bank;
    end
    #3;
    check(wr_ready == e_rdy, op == 2 ? "R4 ready" : (op == 3 ? "R9 ready" : "R3 ready"),
          int'(wr_ready), int'(e_rdy));
    check(buf_we == (e_rdy && v), op == 2 ? "R4 we" : (op == 3 ? "R9 we" : "R5 we"),
          int'(buf_we), int'(e_rdy && v));
    if (e_rdy) begin
      check(buf_col == e_col[7:0], op == 1 ? "R1/R8 col" : "R2 col", int'(buf_col), e_col);
      check(buf_bank == e_bank[0:0], op == 1 ? "R1/R8 bank" : "R2 bank", int'(buf_bank), e_bank);
    end
    check(pre_ok == m_wait, "R6 pre_ok", int'(pre_ok), int'(m_wait));
    check(tras_err == m_err, "R7 tras_err", int'(tras_err), int'(m_err));
    check(rd_data == mem[rb][rc], "R10 rd_data", int'(rd_data), int'(mem[rb][rc]));
    @(posedge clk);
    if (e_rdy && v) mem[e_bank][e_col] = d[15:0];
    stop_evt = m_on && op == 2;
    pre_hit  = (op == 3) && (bank == m_wbank);
    if (pre_hit) m_err = 0;
    else if (m_wait && op != 1 && m_cnt >= lim) m_err = 1;
    if (stop_evt) begin m_wait = 1; m_cnt = 1; m_wbank = m_bank; end
    else if (m_wait && pre_hit) m_wait = 0;
    else if (op == 1) m_wait = 0;
    else if (m_wait && m_cnt < lim) m_cnt++;
    if (op == 1) begin m_on = 1; m_col = (col + 1) % 256; m_bank = bank; end
    else if (m_on && (op == 2 || (op == 3 && bank == m_bank))) m_on = 0;
    else if (m_on) m_col = (m_col + 1) % 256;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    m_on = 0; m_wait = 0; m_err = 0; m_col = 0; m_bank = 0; m_cnt = 0; m_wbank = 0; lim = 5;
    for (int b = 0; b < 2; b++) for (int c = 0; c < 256; c++) mem[b][c] = '0;
    rst_n = 0; cmd_op = 0; cmd_bank = 0; cmd_col = 0; tras_limit = 16'd5;
    wr_valid = 1; wr_data = 16'h1234; rd_bank = 0; rd_col = 0;
    repeat (3) @(negedge clk);
    #3;
    // R11: reset state
    check(!wr_ready && !buf_we, "R11 ready/we in reset", int'(wr_ready), 0);
    check(!pre_ok && !tras_err, "R11 flags in reset", int'(pre_ok), 0);
    @(negedge clk); rst_n = 1;
    cyc(0, 0, 0, 1, 16'h0BAD);
    // R1 R2: start near row end, run past a full wrap, with data gaps (R5)
    cyc(1, 0, 250, 1, 16'hA000);
    for (int i = 1; i < 270; i++) cyc(0, 0, 0, (i % 7) != 3, 16'hA000 + i);
    // R4: stop with valid data held high is not written
    cyc(2, 0, 0, 1, 16'hDEAD);
    cyc(0, 0, 0, 1, 16'hBEEF);
    cyc(2, 1, 0, 1, 16'hBEEF);  // R3: stop while idle has no effect
    cyc(3, 0, 0, 1, 16'h0);     // R6: precharge inside the window
    cyc(0, 0, 0, 0, 0);
    // R7: let the window expire, wrong-bank precharge keeps error
    lim = 4;
    cyc(1, 1, 3, 1, 16'hB000);
    for (int i = 1; i < 10; i++) cyc(0, 0, 0, 1, 16'hB000 + i);
    cyc(2, 0, 0, 1, 16'hDEAD);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 1, 16'h0);
    cyc(3, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(3, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // R8 R9: restart mid burst, other-bank precharge, own-bank precharge
    cyc(1, 0, 10, 1, 16'hC000);
    for (int i = 1; i < 5; i++) cyc(0, 0, 0, 1, 16'hC000 + i);
    cyc(1, 0, 100, 1, 16'hC100);
    for (int i = 1; i < 5; i++) cyc(0, 0, 0, 1, 16'hC100 + i);
    cyc(3, 1, 0, 1, 16'hC1FF);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 16'hC200 + i);
    cyc(3, 0, 0, 1, 16'hDEAD);
    cyc(0, 0, 0, 1, 16'hDEAD);
    // random mix, limits varied across phases
    for (int ph = 0; ph < 4; ph++) begin
      lim = 1 + ph * 3;
      for (int i = 0; i < 700; i++) begin
        int r, op;
        r = $urandom_range(0, 99);
        op = (r < 4) ? 1 : (r < 8) ? 2 : (r < 12) ? 3 : 0;
        cyc(op, $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 3) != 0,
            $urandom_range(0, 65535));
      end
    end
    finish_run();
  end
endmodule